// File: doc/BRIEF.md
# Re-reference Prediction Victim Selector

This block picks which way of a four-way set is replaced when a new entry must be written into a set that is full. Each way keeps a 2-bit prediction value that says how soon the way is expected to be used again. A value of 0 means it is expected soon, and 3 means it is expected late. A hit on a way sets its value to 0. A fill of a way sets it to 2, so a way that is filled but then not used again soon becomes a candidate early. When asked for a victim, the block takes the lowest-index way whose value is 3. If no such way exists, it increments the values and searches again.

Two per-way masks from the surrounding cache steer the choice. A way in the lock mask is pinned: it is never chosen and it is never aged. A way in the dead mask holds an entry that can no longer match any lookup. Such a way is taken before the prediction values are looked at, provided it is not locked. When every way is locked, the block reports that no victim is available and leaves all values as they were.

A request `sel_req` is taken in state IDLE and moves the machine to SCAN. In SCAN the block takes one of two transitions:
- If it can make a decision, it moves to DONE. The decision is one of: no victim (all ways locked), a dead way, or a way at value 3.
- Otherwise it moves to AGE. AGE increments the unlocked values by one and returns to SCAN.

DONE presents the result for one cycle and returns to IDLE. After `sel_req` is sampled at a clock edge, `sel_done` rises after edge 1 + 2·r, where r is the number of aging rounds. The lock and dead masks are expected to stay stable while a request is in progress.

Top module: `srrip_victim_sel`

## Requirements
- R1: After reset every way's prediction value is 3, and `sel_done` is low.
- R2: When `hit_valid` is high at a clock edge, the value of way `hit_way` becomes 0.
- R3: When `fill_valid` is high at a clock edge, the value of way `fill_way` becomes 2.
- R4: When no unlocked way is dead, the victim is the lowest-index unlocked way whose value is 3.
- R5: When no unlocked way is dead and no unlocked way is at 3, each aging round adds 1 to every unlocked value and then searches again. Locked values are unchanged. `sel_done` rises 1 + 2·r clock edges after the edge that samples `sel_req`, where r is the number of rounds.
- R6: A way whose bit is set in `lock_mask` (bit i = way i) is never reported as the victim.
- R7: If any way is set in `dead_mask` (bit i = way i) and clear in `lock_mask`, the victim is the lowest-index such way. No aging takes place.
- R8: If every bit of `lock_mask` is set, `sel_done` and `sel_none` are high together after 1 edge. All values stay unchanged.
- R9: When a fill and a hit target the same way at the same edge, the fill wins and the value becomes 2.
- R10: `sel_done` is high for exactly one cycle per request. `sel_way` is meaningful while `sel_done` is high and `sel_none` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| sel_req | input | 1 | Start a victim search (taken in IDLE) |
| hit_valid | input | 1 | A hit occurred on `hit_way` |
| hit_way | input | 2 | Way index of the hit |
| fill_valid | input | 1 | A fill was written into `fill_way` |
| fill_way | input | 2 | Way index of the fill |
| lock_mask | input | 4 | Pinned ways, bit i = way i |
| dead_mask | input | 4 | Ways holding dead entries, bit i = way i |
| sel_done | output | 1 | One-cycle pulse: result valid |
| sel_none | output | 1 | With `sel_done`: no way can be replaced |
| sel_way | output | 2 | Chosen victim way |

## Verification
Requests are issued with the following value patterns:
- All values equal at 3. This confirms the lowest-index tie rule.
- All values equal at 2 or at 0. These force one or three aging rounds, which the measured latency distinguishes.
- Mixed values. These show that the highest value wins.

Lock patterns covering one way, two ways and all four ways show that pinned ways are skipped and not aged. A later unlocked request reveals whether the pinned values moved. Dead masks that overlap a lock show that dead ways are preferred and that a locked dead way is never used. A fill and a hit in the same cycle on one way are told apart by the victim and the round count that follow.

// File: rtl/srrip_pkg.sv
package srrip_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SCAN,
        ST_AGE,
        ST_DONE
    } sel_state_t;

endpackage

// File: rtl/srrip_rrpv_bank.sv
module srrip_rrpv_bank #(
    parameter int WAYS = 4,
    parameter int RW   = 2,
    localparam int IW  = $clog2(WAYS)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               hit_valid,
    input  logic [IW-1:0]      hit_way,
    input  logic               fill_valid,
    input  logic [IW-1:0]      fill_way,
    input  logic               age_en,
    input  logic [WAYS-1:0]    lock_mask,
    output logic [WAYS*RW-1:0] rr_flat
);

    localparam logic [RW-1:0] RR_MAX  = '1;
    localparam logic [RW-1:0] RR_FILL = RR_MAX - 1'b1;

    for (genvar i = 0; i < WAYS; i++) begin : g_way
        logic [RW-1:0] rr_q;
        logic          fill_me;
        logic          hit_me;

        assign fill_me = fill_valid && (fill_way == IW'(i));
        assign hit_me  = hit_valid  && (hit_way  == IW'(i));

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                rr_q <= RR_MAX;
            end else if (fill_me) begin
                rr_q <= RR_FILL;
            end else if (hit_me) begin
                rr_q <= '0;
            end else if (age_en && !lock_mask[i] && (rr_q != RR_MAX)) begin
                rr_q <= rr_q + 1'b1;
            end
        end

        assign rr_flat[i*RW +: RW] = rr_q;
    end

endmodule

// File: rtl/srrip_pick.sv
module srrip_pick #(
    parameter int WAYS = 4,
    localparam int IW  = $clog2(WAYS)
) (
    input  logic [WAYS-1:0] cand,
    output logic            found,
    output logic [IW-1:0]   idx
);

    always_comb begin
        idx = '0;
        for (int i = WAYS - 1; i >= 0; i--) begin
            if (cand[i]) begin
                idx = IW'(i);
            end
        end
    end

    assign found = |cand;

endmodule

// File: rtl/srrip_victim_sel.sv
module srrip_victim_sel
    import srrip_pkg::*;
#(
    parameter int WAYS = 4,
    parameter int RW   = 2,
    localparam int IW  = $clog2(WAYS)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            sel_req,
    input  logic            hit_valid,
    input  logic [IW-1:0]   hit_way,
    input  logic            fill_valid,
    input  logic [IW-1:0]   fill_way,
    input  logic [WAYS-1:0] lock_mask,
    input  logic [WAYS-1:0] dead_mask,
    output logic            sel_done,
    output logic            sel_none,
    output logic [IW-1:0]   sel_way
);

    localparam logic [RW-1:0] RR_MAX = '1;

    sel_state_t        state_q, state_d;
    logic [WAYS*RW-1:0] rr_flat;
    logic [WAYS-1:0]   at_max;
    logic [WAYS-1:0]   dead_ok;
    logic              dead_found, max_found, all_locked;
    logic [IW-1:0]     dead_idx, max_idx;
    logic              none_q;
    logic [IW-1:0]     way_q;
    logic              age_en;

    srrip_rrpv_bank #(.WAYS(WAYS), .RW(RW)) u_bank (
        .clk        (clk),
        .rst_n      (rst_n),
        .hit_valid  (hit_valid),
        .hit_way    (hit_way),
        .fill_valid (fill_valid),
        .fill_way   (fill_way),
        .age_en     (age_en),
        .lock_mask  (lock_mask),
        .rr_flat    (rr_flat)
    );

    for (genvar i = 0; i < WAYS; i++) begin : g_cand
        assign at_max[i]  = (rr_flat[i*RW +: RW] == RR_MAX) && !lock_mask[i];
        assign dead_ok[i] = dead_mask[i] && !lock_mask[i];
    end

    assign all_locked = &lock_mask;

    srrip_pick #(.WAYS(WAYS)) u_pick_dead (
        .cand  (dead_ok),
        .found (dead_found),
        .idx   (dead_idx)
    );

    srrip_pick #(.WAYS(WAYS)) u_pick_max (
        .cand  (at_max),
        .found (max_found),
        .idx   (max_idx)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (sel_req) state_d = ST_SCAN;
            ST_SCAN: begin
                if (all_locked || dead_found || max_found) begin
                    state_d = ST_DONE;
                end else begin
                    state_d = ST_AGE;
                end
            end
            ST_AGE:  state_d = ST_SCAN;
            ST_DONE: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // decision capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            none_q <= 1'b0;
            way_q  <= '0;
        end else if (state_q == ST_SCAN) begin
            if (all_locked) begin
                none_q <= 1'b1;
                way_q  <= '0;
            end else if (dead_found) begin
                none_q <= 1'b0;
                way_q  <= dead_idx;
            end else if (max_found) begin
                none_q <= 1'b0;
                way_q  <= max_idx;
            end
        end
    end

    // outputs
    always_comb begin
        age_en   = 1'b0;
        sel_done = 1'b0;
        sel_none = 1'b0;
        sel_way  = way_q;
        unique case (state_q)
            ST_AGE:  age_en = 1'b1;
            ST_DONE: begin
                sel_done = 1'b1;
                sel_none = none_q;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/srrip_victim_chk.sv
module srrip_victim_chk #(
    parameter int WAYS = 4,
    parameter int RW   = 2,
    localparam int IW  = $clog2(WAYS)
) (
    input logic               clk,
    input logic               rst_n,
    input logic               hit_valid,
    input logic [IW-1:0]      hit_way,
    input logic               fill_valid,
    input logic [IW-1:0]      fill_way,
    input logic [WAYS-1:0]    lock_mask,
    input logic [WAYS-1:0]    dead_mask,
    input logic               sel_done,
    input logic               sel_none,
    input logic [IW-1:0]      sel_way,
    input logic [WAYS*RW-1:0] rr_flat
);

    logic [WAYS-1:0] dead_free;
    assign dead_free = dead_mask & ~lock_mask;

    // R2
    a_r2_hit_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_valid && !(fill_valid && fill_way == hit_way))
        |=> rr_flat[$past(hit_way)*RW +: RW] == '0);

    // R3 and R9
    a_r3_fill_sets_two: assert property (@(posedge clk) disable iff (!rst_n)
        fill_valid |=> rr_flat[$past(fill_way)*RW +: RW] == {{(RW-1){1'b1}}, 1'b0});

    // R6
    a_r6_locked_never_victim: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_done && !sel_none) |-> (((lock_mask >> sel_way) & 1) == 0));

    // R7
    a_r7_dead_first: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_done && !sel_none && (|dead_free)) |-> (((dead_free >> sel_way) & 1) == 1));

    // R8
    a_r8_none_only_all_locked: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_done && sel_none) |-> (&lock_mask));

    // R10
    a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        sel_done |=> !sel_done);

endmodule

bind srrip_victim_sel srrip_victim_chk #(.WAYS(WAYS), .RW(RW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .hit_valid  (hit_valid),
    .hit_way    (hit_way),
    .fill_valid (fill_valid),
    .fill_way   (fill_way),
    .lock_mask  (lock_mask),
    .dead_mask  (dead_mask),
    .sel_done   (sel_done),
    .sel_none   (sel_none),
    .sel_way    (sel_way),
    .rr_flat    (rr_flat)
);

// File: tb/tb_srrip_victim_sel.sv
module tb_srrip_victim_sel;

    localparam int CLK_PERIOD = 10;
    localparam int WAYS = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sel_req = 1'b0;
    logic       hit_valid = 1'b0;
    logic [1:0] hit_way = '0;
    logic       fill_valid = 1'b0;
    logic [1:0] fill_way = '0;
    logic [3:0] lock_mask = '0;
    logic [3:0] dead_mask = '0;
    logic       sel_done, sel_none;
    logic [1:0] sel_way;

    int checks = 0;
    int errors = 0;
    int m [WAYS];

    always #(CLK_PERIOD/2) clk = ~clk;

    srrip_victim_sel dut (
        .clk(clk), .rst_n(rst_n), .sel_req(sel_req),
        .hit_valid(hit_valid), .hit_way(hit_way),
        .fill_valid(fill_valid), .fill_way(fill_way),
        .lock_mask(lock_mask), .dead_mask(dead_mask),
        .sel_done(sel_done), .sel_none(sel_none), .sel_way(sel_way)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic do_hit(input int w);
        @(negedge clk); hit_valid = 1'b1; hit_way = 2'(w);
        @(negedge clk); hit_valid = 1'b0;
        m[w] = 0;
    endtask

    task automatic do_fill(input int w);
        @(negedge clk); fill_valid = 1'b1; fill_way = 2'(w);
        @(negedge clk); fill_valid = 1'b0;
        m[w] = 2;
    endtask

    task automatic do_both(input int w);
        @(negedge clk);
        fill_valid = 1'b1; fill_way = 2'(w);
        hit_valid = 1'b1; hit_way = 2'(w);
        @(negedge clk); fill_valid = 1'b0; hit_valid = 1'b0;
        m[w] = 2;
    endtask

    // Expected outcome from the requirement model; updates model values
    task automatic predict(output int ew, output bit en, output int rounds);
        bit found;
        ew = 0; en = 0; rounds = 0;
        if (lock_mask == 4'hF) begin
            en = 1;
            return;
        end
        for (int i = WAYS - 1; i >= 0; i--)
            if (dead_mask[i] && !lock_mask[i]) begin
                ew = i;
                en = 0;
            end
        if (|(dead_mask & ~lock_mask)) return;
        found = 0;
        while (!found) begin
            for (int i = WAYS - 1; i >= 0; i--)
                if (!lock_mask[i] && m[i] == 3) begin
                    ew = i;
                    found = 1;
                end
            if (!found) begin
                rounds++;
                for (int i = 0; i < WAYS; i++)
                    if (!lock_mask[i] && m[i] < 3) m[i]++;
            end
        end
    endtask

    task automatic request(input string req);
        int ew, rounds, n;
        bit en;
        predict(ew, en, rounds);
        @(negedge clk); sel_req = 1'b1;
        @(posedge clk);
        @(negedge clk); sel_req = 1'b0;
        n = 0;
        while (!sel_done && n < 100) begin
            @(negedge clk);
            n++;
        end
        check({req, " latency"}, n, 1 + 2 * rounds);
        check({req, " none flag"}, int'(sel_none), int'(en));
        if (!en) check({req, " victim way"}, int'(sel_way), ew);
        @(negedge clk);
        check("R10 done pulse length", int'(sel_done), 0);
    endtask

    task automatic t_reset;
        for (int i = 0; i < WAYS; i++) m[i] = 3;
        repeat (3) @(negedge clk);
        check("R1 done low in reset", int'(sel_done), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 done low after reset", int'(sel_done), 0);
        request("R1 reset values at max, R4 tie to way 0");
    endtask

    task automatic t_hit;
        do_hit(0);
        request("R2 hit way 0, R4 next max way");
    endtask

    task automatic t_fill_age;
        for (int i = 0; i < WAYS; i++) do_fill(i);
        request("R3 fill all, R5 one aging round");
        do_hit(0); do_hit(1); do_hit(2);
        request("R4 only way 3 at max");
        do_hit(3);
        request("R5 three aging rounds from zero");
    endtask

    task automatic t_lock;
        lock_mask = 4'b0001;
        request("R6 way 0 locked");
        for (int i = 0; i < WAYS; i++) do_hit(i);
        lock_mask = 4'b0011;
        request("R6 R5 locked ways skipped during aging");
        lock_mask = 4'b0000;
        request("R5 locked values were not aged");
    endtask

    task automatic t_dead;
        for (int i = 0; i < WAYS; i++) do_hit(i);
        lock_mask = 4'b0010;
        dead_mask = 4'b1010;
        request("R7 locked dead skipped, way 3 dead");
        dead_mask = 4'b0000;
        lock_mask = 4'b0000;
        request("R7 dead pick left values untouched");
    endtask

    task automatic t_all_locked;
        for (int i = 0; i < WAYS; i++) do_fill(i);
        lock_mask = 4'b1111;
        dead_mask = 4'b0101;
        request("R8 all locked");
        lock_mask = 4'b0000;
        dead_mask = 4'b0000;
        request("R8 values unchanged after none");
    endtask

    task automatic t_collide;
        for (int i = 0; i < WAYS; i++) do_hit(i);
        do_both(1);
        request("R9 fill beats hit on same way");
    endtask

    initial begin
        t_reset();
        t_hit();
        t_fill_age();
        t_lock();
        t_dead();
        t_all_locked();
        t_collide();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 100000);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule